// File: doc/BRIEF.md
# Multi-Bank GPIO Interrupt Controller

A memory-mapped general purpose I/O block for up to 96 pins, arranged as banks of 32. Each per-pin setting (drive direction, output data, interrupt enable, trigger polarity, trigger kind, pending status) lives in a small group of 32-bit registers. A group holds one register per bank, and the registers of a group sit 4 bytes apart. Software reads and writes these registers through a single-beat command port with valid/ready handshakes. Read data comes back on a separate response channel.

Every pin input passes through a two-flop synchroniser. Each pin can raise an interrupt in one of four ways: high level, low level, rising edge or falling edge. Edge events stay pending until software writes a 1 to the pin's status bit. Level status tracks the qualified input. All pending pins whose enable bit is set are ORed onto one interrupt output.

The command port takes a command whenever `cmd_valid` and `cmd_ready` are both high at a clock edge. A write completes in that cycle and returns nothing. A read returns its data one cycle later with `rsp_valid` set. The response holds steady until the cycle in which `rsp_ready` is high. While a response is waiting, `cmd_ready` stays low, so back-pressure on the response channel stalls the command channel.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every direction, data, enable, polarity, trigger-kind and status bit is 0, `pin_oe` is all 0, `irq_out` is 0 and `rsp_valid` is 0.
- R2: Pin n is bit n%32 of the register at group base + 4*(n/32). The group bases are: direction 0x014, data 0x024, enable 0x044, polarity 0x104, kind 0x114, status 0x124. Reads of any other offset, 0x000 and 0x004 included, return 0.
- R3: A direction bit of 1 makes the pin an output (`pin_oe` = 1). `pin_out` always shows the data register bit.
- R4: A read of the data group returns the data register bit for output pins and the synchronised input for input pins. The synchronised input follows `pin_in` after two clock edges.
- R5: With kind bit 1 (edge), a polarity bit of 0 sets the status bit on a rising synchronised input and 1 sets it on a falling one. The status bit then stays set after the input returns. The opposite edge sets nothing.
- R6: With kind bit 0 (level), the status bit follows the input one cycle after synchronisation: the input itself when the polarity bit is 0, its inverse when it is 1. Writing 1 to the bit has no lasting effect while the level is active.
- R7: Writing 1 to an edge-mode status bit clears it. Writing 0 leaves it unchanged.
- R8: If an edge event arrives in the same cycle as a write that clears that status bit, the bit stays set.
- R9: `irq_out` is high exactly when some pin has both status and enable set. Status is recorded whether or not the pin is enabled.
- R10: A read response stays valid and stable until `rsp_ready`. `cmd_ready` is low while a response is pending. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 12 | Byte offset of the register |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 96 | Pin input levels (asynchronous) |
| pin_out | output | 96 | Pin output data |
| pin_oe | output | 96 | Pin output enable |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The hardest case to reach is a status-clear write accepted in exactly the clock edge where a new edge event is detected on the same pin. The event appears three edges after the pin changes, behind the two synchroniser flops and the edge-compare stage. The bench toggles the pin on a falling clock edge, waits two more falling edges, and then presents the clearing write, so the command is accepted on the edge where the event is detected. A following read must still see the bit set. A plain clear with no coincident event serves as the control case and must read 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int OFS_W = 12;

  // Base byte offsets of each register group; bank b adds 4*b.
  localparam logic [OFS_W-1:0] OFS_DIR  = 12'h014;
  localparam logic [OFS_W-1:0] OFS_DAT  = 12'h024;
  localparam logic [OFS_W-1:0] OFS_IEN  = 12'h044;
  localparam logic [OFS_W-1:0] OFS_POL  = 12'h104;
  localparam logic [OFS_W-1:0] OFS_KIND = 12'h114;
  localparam logic [OFS_W-1:0] OFS_STAT = 12'h124;

  // Largest bank count that keeps every group clear of the next one.
  localparam int MAX_BANKS = 4;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_DIR,
    FLD_DAT,
    FLD_IEN,
    FLD_POL,
    FLD_KIND,
    FLD_STAT
  } field_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] pin_s,   // synchronised level
  output logic [W-1:0] pin_p    // synchronised level one cycle earlier
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign pin_s = sync_q;
  assign pin_p = prev_q;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,     // a write addressed to this bank
  input  field_e       wr_fld,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] pin_p,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] kind_q,
  output logic [W-1:0] stat_q,
  output logic         bank_irq
);

  logic [W-1:0] qual;
  logic [W-1:0] qual_p;
  logic [W-1:0] edge_evt;
  logic [W-1:0] clr_v;
  logic [W-1:0] stat_d;

  // Polarity folds into the input first, so one rising-edge detector
  // serves both edge directions and a polarity change makes no edge.
  assign qual     = pin_s ^ pol_q;
  assign qual_p   = pin_p ^ pol_q;
  assign edge_evt = qual & ~qual_p;
  assign clr_v    = (wr_en && wr_fld == FLD_STAT) ? wr_data : '0;

  // Edge bits: event sets, write-1 clears, event wins a tie.
  // Level bits: follow the qualified input.
  assign stat_d = (kind_q & (edge_evt | (stat_q & ~clr_v))) | (~kind_q & qual);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dat_q  <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
      kind_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en) begin
        unique case (wr_fld)
          FLD_DIR:  dir_q  <= wr_data;
          FLD_DAT:  dat_q  <= wr_data;
          FLD_IEN:  ien_q  <= wr_data;
          FLD_POL:  pol_q  <= wr_data;
          FLD_KIND: kind_q <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  assign bank_irq = |(stat_q & ien_q);

  // R5: a pending edge bit not being cleared stays pending
  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q & kind_q & ~clr_v) & ~stat_q) == '0));

  // R6: level bits track the qualified input with one cycle of delay
  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_q ^ $past(qual)) & ~$past(kind_q)) == '0));

  // R7: write-1 clears an edge bit when no new event arrives
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_v & kind_q & ~edge_evt) & stat_q) == '0));

  // R8: an edge event always leaves its bit set, clear or not
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(kind_q & edge_evt) & ~stat_q) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_write,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [BANK_W-1:0]           cmd_wdata,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [BANK_W-1:0]           rsp_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  output logic                        irq_out
);

  localparam int NPIN   = NUM_BANKS * BANK_W;
  localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NPIN-1:0]   pin_s;
  logic [NPIN-1:0]   pin_p;
  logic [BANK_W-1:0] dir_a  [NUM_BANKS];
  logic [BANK_W-1:0] dat_a  [NUM_BANKS];
  logic [BANK_W-1:0] ien_a  [NUM_BANKS];
  logic [BANK_W-1:0] pol_a  [NUM_BANKS];
  logic [BANK_W-1:0] kind_a [NUM_BANKS];
  logic [BANK_W-1:0] stat_a [NUM_BANKS];
  logic [BANK_W-1:0] sin_a  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  field_e            fsel;
  logic [BSEL_W-1:0] bsel;
  logic              cmd_fire;
  logic              wr_fire;
  logic              rd_fire;
  logic [BANK_W-1:0] rd_val;

  // ---------------- input synchroniser ----------------
  gpio_pin_sync #(.W(NPIN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_in),
    .pin_s   (pin_s),
    .pin_p   (pin_p)
  );

  // ---------------- address decode ----------------
  always_comb begin
    fsel = FLD_NONE;
    bsel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (cmd_addr == ADDR_W'(OFS_DIR) + ADDR_W'(4 * b)) begin
        fsel = FLD_DIR;  bsel = BSEL_W'(b);
      end
      if (cmd_addr == ADDR_W'(OFS_DAT) + ADDR_W'(4 * b)) begin
        fsel = FLD_DAT;  bsel = BSEL_W'(b);
      end
      if (cmd_addr == ADDR_W'(OFS_IEN) + ADDR_W'(4 * b)) begin
        fsel = FLD_IEN;  bsel = BSEL_W'(b);
      end
      if (cmd_addr == ADDR_W'(OFS_POL) + ADDR_W'(4 * b)) begin
        fsel = FLD_POL;  bsel = BSEL_W'(b);
      end
      if (cmd_addr == ADDR_W'(OFS_KIND) + ADDR_W'(4 * b)) begin
        fsel = FLD_KIND; bsel = BSEL_W'(b);
      end
      if (cmd_addr == ADDR_W'(OFS_STAT) + ADDR_W'(4 * b)) begin
        fsel = FLD_STAT; bsel = BSEL_W'(b);
      end
    end
  end

  assign cmd_ready = !rsp_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign wr_fire   = cmd_fire && cmd_write;
  assign rd_fire   = cmd_fire && !cmd_write;

  // ---------------- banks ----------------
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    gpio_irq_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fire && (bsel == BSEL_W'(g))),
      .wr_fld   (fsel),
      .wr_data  (cmd_wdata),
      .pin_s    (pin_s[g*BANK_W +: BANK_W]),
      .pin_p    (pin_p[g*BANK_W +: BANK_W]),
      .dir_q    (dir_a[g]),
      .dat_q    (dat_a[g]),
      .ien_q    (ien_a[g]),
      .pol_q    (pol_a[g]),
      .kind_q   (kind_a[g]),
      .stat_q   (stat_a[g]),
      .bank_irq (bank_irq[g])
    );
    assign sin_a[g]                     = pin_s[g*BANK_W +: BANK_W];
    assign pin_out[g*BANK_W +: BANK_W]  = dat_a[g];
    assign pin_oe[g*BANK_W +: BANK_W]   = dir_a[g];
  end

  assign irq_out = |bank_irq;

  // ---------------- read path ----------------
  always_comb begin
    unique case (fsel)
      FLD_DIR:  rd_val = dir_a[bsel];
      FLD_DAT:  rd_val = (dir_a[bsel] & dat_a[bsel]) | (~dir_a[bsel] & sin_a[bsel]);
      FLD_IEN:  rd_val = ien_a[bsel];
      FLD_POL:  rd_val = pol_a[bsel];
      FLD_KIND: rd_val = kind_a[bsel];
      FLD_STAT: rd_val = stat_a[bsel];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // ---------------- checks ----------------
  logic any_ien;
  always_comb begin
    any_ien = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) any_ien = any_ien | (|ien_a[b]);
  end

  initial begin
    p_bank_fit_r2: assert (NUM_BANKS >= 1 && NUM_BANKS <= MAX_BANKS && ADDR_W >= OFS_W);
  end

  // R10: no new command while a response waits
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R10: a stalled response holds its data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10: writes never raise a response
  p_wr_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !rsp_valid) |=> !rsp_valid);

  // R9: the interrupt needs at least one enabled pin
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> any_ien);

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

  localparam int NB = 3;
  localparam int BW = 32;
  localparam int AW = 12;
  localparam int NP = NB * BW;

  localparam logic [AW-1:0] A_DIR  = 12'h014;
  localparam logic [AW-1:0] A_DAT  = 12'h024;
  localparam logic [AW-1:0] A_IEN  = 12'h044;
  localparam logic [AW-1:0] A_POL  = 12'h104;
  localparam logic [AW-1:0] A_KIND = 12'h114;
  localparam logic [AW-1:0] A_STAT = 12'h124;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [BW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [BW-1:0] rsp_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [BW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  gpio_irq_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act,
                     input logic [BW-1:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard when a response is taken.
  always @(negedge clk) begin
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", rsp_rdata, '0);
      end else begin
        logic [BW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Both bus tasks are entered right after a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [BW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk(irq_out === 1'b0, "R1 irq after reset", {31'b0, irq_out}, 0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", {31'b0, rsp_valid}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(pin_oe === '0, "R1 pin_oe after reset", pin_oe[31:0], 0);
    rd(A_DIR, 0, "R1 dir bank0");
    rd(A_IEN + 12'h8, 0, "R1 enable bank2");
    rd(A_STAT + 12'h4, 0, "R1 status bank1");

    // R2: unmapped offsets read zero
    rd(12'h000, 0, "R2 offset 0x000");
    rd(12'h004, 0, "R2 offset 0x004");
    rd(12'h020, 0, "R2 offset 0x020");
    rd(12'h130, 0, "R2 offset 0x130");

    // R3/R4: bank1 direction and data, pins 40..47 as outputs
    pin_in[63:32] = 32'h1234_5678;
    wr(A_DIR + 12'h4, 32'h0000_FF00);
    wr(A_DAT + 12'h4, 32'h0000_A500);
    chk(rsp_valid === 1'b0, "R10 write gives no response", {31'b0, rsp_valid}, 0);
    chk(pin_oe[47:40] === 8'hFF && pin_oe[39:32] === 8'h00, "R3 pin_oe bank1",
        pin_oe[63:32], 32'h0000_FF00);
    chk(pin_out[63:32] === 32'h0000_A500, "R3 pin_out bank1", pin_out[63:32], 32'h0000_A500);
    rd(A_DIR + 12'h4, 32'h0000_FF00, "R2 dir bank1 readback");
    rd(A_DAT + 12'h4, 32'h1234_A578, "R4 mixed data read bank1");

    // R6: level, active high, status follows pins; clear has no lasting effect
    rd(A_STAT + 12'h4, 32'h1234_5678, "R6 level high follows");
    chk(irq_out === 1'b0, "R9 status without enable", {31'b0, irq_out}, 0);
    wr(A_STAT + 12'h4, 32'hFFFF_FFFF);
    rd(A_STAT + 12'h4, 32'h1234_5678, "R6 clear while active");
    pin_in[63:32] = '0;
    wait_cyc(4);
    rd(A_STAT + 12'h4, 0, "R6 level drops with input");
    wr(A_POL + 12'h4, 32'h1);
    wait_cyc(2);
    rd(A_STAT + 12'h4, 32'h1, "R6 level low pin32");
    wr(A_IEN + 12'h4, 32'h1);
    chk(irq_out === 1'b1, "R9 irq from level low", {31'b0, irq_out}, 1);
    pin_in[32] = 1'b1;
    wait_cyc(4);
    chk(irq_out === 1'b0, "R9 irq follows level away", {31'b0, irq_out}, 0);
    wr(A_IEN + 12'h4, 32'h0);

    // R5/R7: rising edge on pin 3
    wr(A_KIND, 32'h8);
    wr(A_IEN, 32'h8);
    pin_in[3] = 1'b1;
    wait_cyc(4);
    chk(irq_out === 1'b1, "R5 rising edge raises irq", {31'b0, irq_out}, 1);
    pin_in[3] = 1'b0;
    wait_cyc(4);
    rd(A_STAT, 32'h8, "R5 edge status sticky");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h8, "R7 write zero no effect");
    wr(A_STAT, 32'h8);
    chk(irq_out === 1'b0, "R7 clear drops irq", {31'b0, irq_out}, 0);
    rd(A_STAT, 32'h0, "R7 write one clears");

    // R5/R9: falling edge on pin 70 (bank2 bit 6)
    wr(A_KIND + 12'h8, 32'h40);
    wr(A_POL + 12'h8, 32'h40);
    pin_in[70] = 1'b1;
    wait_cyc(4);
    rd(A_STAT + 12'h8, 32'h0, "R5 rising ignored in falling mode");
    pin_in[70] = 1'b0;
    wait_cyc(4);
    rd(A_STAT + 12'h8, 32'h40, "R5 falling edge bank2");
    chk(irq_out === 1'b0, "R9 disabled pin no irq", {31'b0, irq_out}, 0);
    wr(A_IEN + 12'h8, 32'h40);
    chk(irq_out === 1'b1, "R9 enable exposes pending", {31'b0, irq_out}, 1);
    wr(A_STAT + 12'h8, 32'h40);
    chk(irq_out === 1'b0, "R7 clear bank2", {31'b0, irq_out}, 0);

    // R8: clear accepted on the same edge as a new rising event on pin 3
    pin_in[3] = 1'b1;
    wait_cyc(2);
    wr(A_STAT, 32'h8);
    rd(A_STAT, 32'h8, "R8 event wins over clear");
    wr(A_STAT, 32'h8);
    rd(A_STAT, 32'h0, "R7 control clear");

    // R10: response back-pressure
    rsp_ready = 1'b0;
    exp_q.push_back(32'h0000_FF00);
    tag_q.push_back("R10 stalled response data");
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = A_DIR + 12'h4;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && cmd_ready === 1'b0, "R10 response held, port busy",
          {30'b0, rsp_valid, cmd_ready}, 32'h2);
      chk(rsp_rdata === 32'h0000_FF00, "R10 held data stable", rsp_rdata, 32'h0000_FF00);
    end
    rsp_ready = 1'b1;
    wait_cyc(2);
    chk(rsp_valid === 1'b0 && cmd_ready === 1'b1, "R10 released",
        {30'b0, rsp_valid, cmd_ready}, 32'h1);
    chk(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule